// File: doc/BRIEF.md
# Flag-Setting Bitwise Logic Unit

This block is the bitwise half of an integer execute stage. It combines a first operand with a second operand that an upstream shifter has already produced. The combination is chosen from five bitwise operations: AND, exclusive OR, inclusive OR, AND with the inverted second operand (bit clear) and OR with the inverted second operand (OR-NOT). The result leaves the block combinationally in the same cycle the inputs are presented.

The block also holds the four condition flags: negative, zero, carry and overflow. On a rising clock edge where the enable strobe, the set-flags request and a legal operation code are all present, negative and zero are loaded from the result. Carry is loaded from the carry bit the upstream shifter produced, and overflow keeps its value. In every other cycle all four flags hold. A synchronous reset clears the flags. The data path has no flow control: each cycle stands alone, so no valid/ready handshake or back-pressure applies, and all pins are plain control and data.

Top module: `flag_logic_unit`

## Requirements
- R1: With operation code 0, `res_o` equals `opa_i & opb_i`.
- R2: With operation code 1, `res_o` equals `opa_i ^ opb_i`.
- R3: With operation code 2, `res_o` equals `opa_i | opb_i`.
- R4: With operation code 3 (bit clear), `res_o` equals `opa_i & ~opb_i`.
- R5: With operation code 4 (OR-NOT), `res_o` equals `opa_i | ~opb_i`.
- R6: With operation codes 5, 6 and 7, `res_o` is all zeros and no flag changes at the next edge, even with `stb_i` and `setf_i` high.
- R7: `res_o` follows changes of `opa_i`, `opb_i` and `op_i` within the same cycle, with no clock edge between.
- R8: After a rising edge with `stb_i`=1, `setf_i`=1 and a legal code, `flag_n_o` equals bit 31 of the result presented before that edge.
- R9: After such an edge, `flag_z_o` is 1 exactly when that result was all zeros.
- R10: After such an edge, `flag_c_o` equals the `shc_i` presented before that edge.
- R11: `flag_v_o` is never changed by any operation, with or without `setf_i`; out of reset it stays 0.
- R12: When `stb_i` or `setf_i` is 0 at an edge, all four flags keep their values.
- R13: A rising edge with `rst_i`=1 clears all four flags to 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, flags update on rising edge |
| rst_i | input | 1 | Synchronous reset, active high, clears flags |
| stb_i | input | 1 | Enable strobe for the flag registers |
| setf_i | input | 1 | Set-flags request |
| op_i | input | 3 | Operation code: 0 AND, 1 XOR, 2 OR, 3 bit clear, 4 OR-NOT, 5..7 unused |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Carry out of the operand shifter |
| res_o | output | 32 | Combinational result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Every operation code is driven with complementary operand pairs, all-ones and all-zeros operands and random words. These patterns separate the five bitwise functions from one another and from a swapped or uninverted operand. The zero flag is exercised by operand pairs that cancel to exactly zero for each operation, and by a result whose only set bit is the top or bottom bit. These cases tell a correct full-width zero detect from one that misses a chunk. Strobe and set-flags are toggled on their own, and unused codes are applied with both high, so that a flag loading on the wrong condition shows. A reference model kept in the bench predicts the result and the flags every cycle.

// File: rtl/flu_pkg.sv
package flu_pkg;

  localparam int unsigned FLU_OP_W   = 3;
  localparam int unsigned FLU_NUM_OP = 5;

  typedef enum logic [FLU_OP_W-1:0] {
    FLU_AND  = 3'd0,
    FLU_XOR  = 3'd1,
    FLU_IOR  = 3'd2,
    FLU_CLR  = 3'd3,
    FLU_ONOT = 3'd4
  } flu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flu_flags_t;

  function automatic logic flu_op_legal(input logic [FLU_OP_W-1:0] code);
    return code < FLU_OP_W'(FLU_NUM_OP);
  endfunction

endpackage

// File: rtl/flu_logic_core.sv
module flu_logic_core
  import flu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [FLU_OP_W-1:0] sel_i,
  output logic [W-1:0]        y_o,
  output logic                legal_o
);

  logic [W-1:0] b_n;
  logic [W-1:0] cand [FLU_NUM_OP];

  assign b_n = ~b_i;

  // one candidate vector per operation code
  for (genvar k = 0; k < FLU_NUM_OP; k++) begin : g_cand
    if (k == int'(FLU_AND)) begin : g_and
      assign cand[k] = a_i & b_i;
    end else if (k == int'(FLU_XOR)) begin : g_xor
      assign cand[k] = a_i ^ b_i;
    end else if (k == int'(FLU_IOR)) begin : g_ior
      assign cand[k] = a_i | b_i;
    end else if (k == int'(FLU_CLR)) begin : g_clr
      assign cand[k] = a_i & b_n;
    end else begin : g_onot
      assign cand[k] = a_i | b_n;
    end
  end

  assign legal_o = flu_op_legal(sel_i);

  always_comb begin
    y_o = '0;
    for (int i = 0; i < FLU_NUM_OP; i++) begin
      if (sel_i == FLU_OP_W'(i)) y_o = cand[i];
    end
  end

endmodule

// File: rtl/flu_zero_detect.sv
module flu_zero_detect #(
  parameter int unsigned W     = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [W-1:0] d_i,
  output logic         zero_o
);

  localparam int unsigned NCH  = (W + CHUNK - 1) / CHUNK;
  localparam int unsigned PADW = NCH * CHUNK;

  logic [PADW-1:0] pad;
  logic [NCH-1:0]  any;

  always_comb begin
    pad        = '0;
    pad[W-1:0] = d_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign any[g] = |pad[g*CHUNK +: CHUNK];
  end

  assign zero_o = ~|any;

endmodule

// File: rtl/flu_flag_reg.sv
module flu_flag_reg
  import flu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_i,
  input  logic       n_d_i,
  input  logic       z_d_i,
  input  logic       c_d_i,
  output flu_flags_t q_o
);

  flu_flags_t q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q <= '0;
    end else if (load_i) begin
      q.n <= n_d_i;
      q.z <= z_d_i;
      q.c <= c_d_i;
      // overflow is left as it is
    end
  end

  assign q_o = q;

endmodule

// File: rtl/flag_logic_unit.sv
module flag_logic_unit
  import flu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                stb_i,
  input  logic                setf_i,
  input  logic [FLU_OP_W-1:0] op_i,
  input  logic [W-1:0]        opa_i,
  input  logic [W-1:0]        opb_i,
  input  logic                shc_i,
  output logic [W-1:0]        res_o,
  output logic                flag_n_o,
  output logic                flag_z_o,
  output logic                flag_c_o,
  output logic                flag_v_o
);

  localparam int unsigned MSB = W - 1;

  logic       legal;
  logic       res_zero;
  logic       load;
  flu_flags_t flags;

  flu_logic_core #(.W(W)) u_core (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sel_i   (op_i),
    .y_o     (res_o),
    .legal_o (legal)
  );

  flu_zero_detect #(.W(W), .CHUNK(CHUNK)) u_zdet (
    .d_i    (res_o),
    .zero_o (res_zero)
  );

  assign load = stb_i & setf_i & legal;

  flu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .n_d_i  (res_o[MSB]),
    .z_d_i  (res_zero),
    .c_d_i  (shc_i),
    .q_o    (flags)
  );

  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_v_o = flags.v;

endmodule

// File: rtl/flag_logic_unit_checker.sv
module flag_logic_unit_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         stb_i,
  input logic         setf_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         shc_i,
  input logic [W-1:0] res_o,
  input logic         flag_n_o,
  input logic         flag_z_o,
  input logic         flag_c_o,
  input logic         flag_v_o
);

  AST_CLR_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 3'd3) |-> (res_o == (opa_i & ~opb_i))); // R4
  AST_ONOT_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 3'd4) |-> (res_o == (opa_i | ~opb_i))); // R5
  AST_BADOP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i > 3'd4) |-> (res_o == '0)); // R6
  AST_BADOP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i > 3'd4) |=> $stable({flag_n_o, flag_z_o, flag_c_o})); // R6
  AST_N_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && setf_i && op_i < 3'd5) |=> (flag_n_o == $past(res_o[W-1]))); // R8
  AST_Z_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && setf_i && op_i < 3'd5) |=> (flag_z_o == ($past(res_o) == '0))); // R9
  AST_C_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && setf_i && op_i < 3'd5) |=> (flag_c_o == $past(shc_i))); // R10
  AST_V_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !flag_v_o); // R11
  AST_NOSET_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(stb_i && setf_i) |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o})); // R12
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> !(flag_n_o || flag_z_o || flag_c_o || flag_v_o)); // R13

endmodule

bind flag_logic_unit flag_logic_unit_checker #(.W(W)) u_chk (.*);

// File: tb/flag_logic_unit_tb_top.sv
module flag_logic_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_i = 1'b1;
  logic         stb_i = 1'b0;
  logic         setf_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         shc_i = 1'b0;
  logic [W-1:0] res_o;
  logic         flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int n_chk = 0;
  int n_bad = 0;
  // reference flags: n, z, c, v
  logic [3:0] m_flags = 4'b0000;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flag_logic_unit dut_i (.*);

  function automatic logic [W-1:0] ref_res(input logic [2:0] c,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    case (c)
      3'd0:    return a & b;
      3'd1:    return a ^ b;
      3'd2:    return a | b;
      3'd3:    return a & ~b;
      3'd4:    return a | ~b;
      default: return '0;
    endcase
  endfunction

  function automatic string res_tag(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_flags(input string tag);
    cmp({tag, " N"}, W'(flag_n_o), W'(m_flags[3]));
    cmp({tag, " Z"}, W'(flag_z_o), W'(m_flags[2]));
    cmp({tag, " C"}, W'(flag_c_o), W'(m_flags[1]));
    cmp("R11 V", W'(flag_v_o), W'(m_flags[0]));
  endtask

  // one cycle: drive after negedge, check result, step model at edge, check flags
  task automatic step(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sc, input logic st, input logic sf);
    logic [W-1:0] r;
    string ftag;
    @(negedge clk_i);
    op_i = c; opa_i = a; opb_i = b; shc_i = sc; stb_i = st; setf_i = sf;
    #1;
    r = ref_res(c, a, b);
    cmp(res_tag(c), res_o, r);
    @(posedge clk_i);
    if (st && sf && c < 3'd5) begin
      m_flags[3] = r[W-1];
      m_flags[2] = (r == '0);
      m_flags[1] = sc;
      ftag = "R8/R9/R10 load";
    end else if (c >= 3'd5) begin
      ftag = "R6 hold";
    end else begin
      ftag = "R12 hold";
    end
    #1;
    cmp_flags(ftag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(posedge clk_i);
    #1;
    cmp_flags("R13 reset");
    @(negedge clk_i);
    rst_i = 1'b0;

    // complementary and extreme patterns for each code, flags loaded
    for (int c = 0; c < 8; c++) begin
      step(3'(c), 32'hF0F0_A5A5, 32'h0F0F_5A5A, 1'b1, 1'b1, 1'b1);
      step(3'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
      step(3'(c), 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1);
      step(3'(c), 32'h8000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b1);
    end

    // zero-flag corners: exactly cancelling operands per code
    step(3'd0, 32'h1234_5678, 32'hEDCB_A987, 1'b1, 1'b1, 1'b1); // R9 and -> 0
    step(3'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1); // R9 xor -> 0
    step(3'd3, 32'h00FF_00FF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1); // R4/R9 clr -> 0
    step(3'd4, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1); // R5/R9 onot -> 0
    step(3'd2, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1); // R8 top bit only
    step(3'd2, 32'h0000_0000, 32'h0000_0100, 1'b0, 1'b1, 1'b1); // R9 single middle bit

    // strobe or set-flags low: flags hold (R12)
    step(3'd1, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1);
    step(3'd1, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0);
    step(3'd2, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0);

    // R7: result tracks inputs with no clock edge in between
    @(negedge clk_i);
    op_i = 3'd1; opa_i = 32'h0000_FFFF; opb_i = 32'h00FF_00FF;
    #1 cmp("R7 first", res_o, 32'h00FF_FF00);
    op_i = 3'd3;
    #1 cmp("R7 op change", res_o, 32'h0000_FF00);
    opb_i = 32'h0;
    #1 cmp("R7 operand change", res_o, 32'h0000_FFFF);
    stb_i = 1'b0;
    @(posedge clk_i);

    // random vectors across all codes and control combinations
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      step(rnd[2:0], $urandom, $urandom, rnd[3], rnd[4] | rnd[6], rnd[5] | rnd[7]);
    end

    // R13: set flags to nonzero, then reset with a load pending
    step(3'd2, 32'h8000_0000, 32'h0, 1'b1, 1'b1, 1'b1);
    @(negedge clk_i);
    rst_i = 1'b1; stb_i = 1'b1; setf_i = 1'b1; op_i = 3'd4; shc_i = 1'b1;
    @(posedge clk_i);
    m_flags = 4'b0000;
    #1 cmp_flags("R13 reset");
    @(negedge clk_i);
    rst_i = 1'b0; stb_i = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule